// File: doc/BRIEF.md
# Three-Channel Match Timer with Capture Read

This block holds several up-counters that advance on a slow functional clock, while software reaches them over a plain register port on an unrelated bus clock. Each counter has a set of equality comparators. One of them may be chosen to reload the counter from a preload word, which gives periodic timebases. If no comparator is chosen, or if the chosen match sits at the top of the range with a preload of zero, the counter wraps through its full width. Every comparator hit sets a sticky status bit. Status bits that are enabled drive one interrupt line.

A live count is never read straight across the clock boundary. Software writes 1 to a channel's capture address, which sets that channel's busy bit. The request toggle crosses into the counter domain through two flops, and the count is latched there into a holding word. An acknowledge toggle returns through two flops. The holding word is copied into the bus-side capture register only after the acknowledge arrives, and busy clears in the same cycle, so the word is stable before software sees it. The register port has no back-pressure. Writes complete in one bus cycle and read data follows the address combinationally. Configuration words are used directly by the counter domain and must only be changed while the channel is disabled.

Top module: `mtm_timer_top`

## Requirements
- R1: A counter advances by one per functional clock while its enable bit (bit t of the enable word, address 15) is 1, and it holds its value while that bit is 0.
- R2: Reload select word s of channel t (addresses 12..14, 2 bits) selects comparator s-1 for s = 1..3; 0 selects none. When the selected comparator equals the count, the next count is the preload word (addresses 9..11) instead of count+1.
- R3: Counting wraps from 0xFFFFFFFF to 0. With match 0xFFFFFFFF selected and preload 0, the counter passes through the top of the range back to small values.
- R4: Writing a value with bit 0 set to capture address 19+t sets busy bit t (address 22). When busy clears, a read of 19+t returns the count at the instant the request was seen, and that value stays stable while busy is 0.
- R5: A capture write with bit 0 clear, or one that arrives while the channel is busy, starts no capture and leaves the captured value unchanged.
- R6: When count t equals match word 3t+k (addresses 0..8) while enabled, status bit 3t+k (address 16) becomes 1 and stays 1 until it is cleared.
- R7: Writing 1s to the clear address (18) clears those status bits, and reads of address 18 return 0.
- R8: irq is 1 one bus cycle after some status bit and its enable bit (address 17) are both 1, and it is 0 while no enabled status bit is set.
- R9: Configuration words read back as written, masked to their field width (match and preload 32 bits, select 2 bits, enable 3 bits, interrupt enable 9 bits).
- R10: The channels are independent: running one changes neither the count nor the status bits of another.
- R11: After reset all registers read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low, synchronous |
| fclk | input | 1 | Functional counter clock |
| frst_n | input | 1 | Counter-domain reset, active low, synchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The counters are run with a reload on comparator 0, with a reload on comparator 1 and with a high preload that forces the full-range wrap. In each case the captured value must fall inside the window that the selected match and preload define, which separates a correct reload from a free-running or wrong-comparator counter. Captures are taken with the channel stopped, where two reads must agree exactly, and while it runs. Both are done at functional clock periods of 13 ns and 37 ns against the 5 ns bus clock, so the two clocks never align on integer ratios. Status, clear and interrupt masking are checked against a behavioural register model, and a second and third channel left idle must stay at zero.

// File: rtl/mtm_pkg.sv
`timescale 1ns/1ps
package mtm_pkg;
  // number of flops in every clock-crossing stage
  localparam int unsigned MTM_SYNC_STAGES = 2;

  // width of a reload-select field: code 0 = none, codes 1..n = comparator 0..n-1
  function automatic int sel_width(input int ncmp);
    return $clog2(ncmp + 1);
  endfunction
endpackage

// File: rtl/mtm_sync.sv
`timescale 1ns/1ps
module mtm_sync import mtm_pkg::*; #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [MTM_SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MTM_SYNC_STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < MTM_SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[MTM_SYNC_STAGES-1];
endmodule

// File: rtl/mtm_chan.sv
`timescale 1ns/1ps
module mtm_chan #(
  parameter int CW   = 32,
  parameter int NCMP = 3,
  parameter int SW   = 2
) (
  input  logic             fclk,
  input  logic             frst_n,
  input  logic             run,
  input  logic [NCMP*CW-1:0] match_flat,
  input  logic [CW-1:0]    preload,
  input  logic [SW-1:0]    rsel,
  input  logic             cap_req,
  output logic [CW-1:0]    hold,
  output logic             cap_ack,
  output logic [NCMP-1:0]  evt_tgl
);
  logic [CW-1:0]   count;
  logic [NCMP-1:0] hit;
  logic            reload;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign hit[k] = (count == match_flat[k*CW +: CW]);
  end

  always_comb begin
    reload = 1'b0;
    for (int k = 0; k < NCMP; k++)
      if (rsel == SW'(k + 1) && hit[k]) reload = 1'b1;
  end

  // counter and one toggle per comparator hit (a hit that also reloads toggles once)
  always_ff @(posedge fclk) begin
    if (!frst_n) begin
      count   <= '0;
      evt_tgl <= '0;
    end else if (run) begin
      count   <= reload ? preload : count + CW'(1);
      evt_tgl <= evt_tgl ^ hit;
    end
  end

  // capture responder: latch the count on each new request toggle
  always_ff @(posedge fclk) begin
    if (!frst_n) begin
      cap_ack <= 1'b0;
      hold    <= '0;
    end else if (cap_req != cap_ack) begin
      cap_ack <= cap_req;
      hold    <= count;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge fclk) disable iff (!frst_n)
    !run |=> $stable(count)); // R1

  AST_RELOAD_TAKEN: assert property (@(posedge fclk) disable iff (!frst_n)
    (run && rsel == SW'(1) && count == match_flat[CW-1:0]) |=> (count == $past(preload))); // R2

  AST_HOLD_QUIET: assert property (@(posedge fclk) disable iff (!frst_n)
    (cap_req == cap_ack) |=> $stable(hold)); // R4
endmodule

// File: rtl/mtm_timer_top.sv
`timescale 1ns/1ps
module mtm_timer_top import mtm_pkg::*; #(
  parameter int NTMR = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fclk,
  input  logic          frst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NM      = NTMR * NCMP;
  localparam int SW      = sel_width(NCMP);
  localparam int A_MATCH = 0;
  localparam int A_PRE   = A_MATCH + NM;
  localparam int A_SEL   = A_PRE + NTMR;
  localparam int A_EN    = A_SEL + NTMR;
  localparam int A_STS   = A_EN + 1;
  localparam int A_IE    = A_STS + 1;
  localparam int A_CLR   = A_IE + 1;
  localparam int A_CAP   = A_CLR + 1;
  localparam int A_BUSY  = A_CAP + NTMR;

  // bus-domain state
  logic [CW-1:0]   match_q [NM];
  logic [CW-1:0]   pre_q   [NTMR];
  logic [SW-1:0]   sel_q   [NTMR];
  logic [NTMR-1:0] en_q;
  logic [NM-1:0]   ie_q, sts_q;
  logic [CW-1:0]   cap_q   [NTMR];
  logic [NTMR-1:0] busy_q, req_tgl, ack_prev;
  logic [NM-1:0]   evt_prev;
  logic            irq_q;

  // crossing signals
  logic [NTMR-1:0] run_f, req_f, ack_f, ack_s;
  logic [NM-1:0]   evt_f, evt_s;
  logic [CW-1:0]   hold_f [NTMR];

  logic [NM-1:0]   clr_mask;
  logic [NTMR-1:0] cap_wr;

  assign clr_mask = (bus_wr && bus_addr == AW'(A_CLR)) ? bus_wdata[NM-1:0] : '0;

  for (genvar t = 0; t < NTMR; t++) begin : g_capwr
    assign cap_wr[t] = bus_wr && bus_addr == AW'(A_CAP + t) && bus_wdata[0];
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) match_q[i] <= '0;
      for (int t = 0; t < NTMR; t++) begin
        pre_q[t] <= '0;
        sel_q[t] <= '0;
      end
      en_q <= '0;
      ie_q <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NM; i++)
        if (bus_addr == AW'(A_MATCH + i)) match_q[i] <= bus_wdata;
      for (int t = 0; t < NTMR; t++) begin
        if (bus_addr == AW'(A_PRE + t)) pre_q[t] <= bus_wdata;
        if (bus_addr == AW'(A_SEL + t)) sel_q[t] <= bus_wdata[SW-1:0];
      end
      if (bus_addr == AW'(A_EN)) en_q <= bus_wdata[NTMR-1:0];
      if (bus_addr == AW'(A_IE)) ie_q <= bus_wdata[NM-1:0];
    end
  end

  // sticky status from synchronised event toggles; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_prev <= '0;
      sts_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      evt_prev <= evt_s;
      sts_q    <= (sts_q & ~clr_mask) | (evt_s ^ evt_prev);
      irq_q    <= |(sts_q & ie_q);
    end
  end

  // capture request / acknowledge handshake, bus side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= '0;
      req_tgl  <= '0;
      ack_prev <= '0;
      for (int t = 0; t < NTMR; t++) cap_q[t] <= '0;
    end else begin
      ack_prev <= ack_s;
      for (int t = 0; t < NTMR; t++) begin
        if (ack_s[t] != ack_prev[t]) begin
          cap_q[t]  <= hold_f[t];
          busy_q[t] <= 1'b0;
        end else if (cap_wr[t] && !busy_q[t]) begin
          req_tgl[t] <= ~req_tgl[t];
          busy_q[t]  <= 1'b1;
        end
      end
    end
  end

  mtm_sync #(.W(NTMR)) u_sync_en  (.clk(fclk), .rst_n(frst_n), .d(en_q),    .q(run_f));
  mtm_sync #(.W(NTMR)) u_sync_req (.clk(fclk), .rst_n(frst_n), .d(req_tgl), .q(req_f));
  mtm_sync #(.W(NTMR)) u_sync_ack (.clk(clk),  .rst_n(rst_n),  .d(ack_f),   .q(ack_s));
  mtm_sync #(.W(NM))   u_sync_evt (.clk(clk),  .rst_n(rst_n),  .d(evt_f),   .q(evt_s));

  for (genvar t = 0; t < NTMR; t++) begin : g_chan
    logic [NCMP*CW-1:0] mflat;
    for (genvar k = 0; k < NCMP; k++) begin : g_m
      assign mflat[k*CW +: CW] = match_q[t*NCMP + k];
    end
    mtm_chan #(.CW(CW), .NCMP(NCMP), .SW(SW)) u_chan (
      .fclk      (fclk),
      .frst_n    (frst_n),
      .run       (run_f[t]),
      .match_flat(mflat),
      .preload   (pre_q[t]),
      .rsel      (sel_q[t]),
      .cap_req   (req_f[t]),
      .hold      (hold_f[t]),
      .cap_ack   (ack_f[t]),
      .evt_tgl   (evt_f[t*NCMP +: NCMP])
    );

    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q[t] |=> $stable(cap_q[t])); // R4

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[t] && cap_wr[t]) |=> $stable(req_tgl[t])); // R5
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NM; i++)
      if (bus_addr == AW'(A_MATCH + i)) bus_rdata = match_q[i];
    for (int t = 0; t < NTMR; t++) begin
      if (bus_addr == AW'(A_PRE + t)) bus_rdata = pre_q[t];
      if (bus_addr == AW'(A_SEL + t)) bus_rdata = CW'(sel_q[t]);
      if (bus_addr == AW'(A_CAP + t)) bus_rdata = cap_q[t];
    end
    if (bus_addr == AW'(A_EN))   bus_rdata = CW'(en_q);
    if (bus_addr == AW'(A_STS))  bus_rdata = CW'(sts_q);
    if (bus_addr == AW'(A_IE))   bus_rdata = CW'(ie_q);
    if (bus_addr == AW'(A_BUSY)) bus_rdata = CW'(busy_q);
  end

  assign irq = irq_q;

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |=> !irq); // R8

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0 && (evt_s ^ evt_prev) == '0) |=> ((sts_q & $past(clr_mask)) == '0)); // R7
endmodule

// File: tb/sim_mtm_timer_top.sv
`timescale 1ns/1ps
module sim_mtm_timer_top;
  localparam int A_PRE = 9, A_SEL = 12, A_EN = 15, A_STS = 16, A_IE = 17,
                 A_CLR = 18, A_CAP = 19, A_BUSY = 22;

  logic        clk = 1'b0, fclk = 1'b0;
  logic        rst_n = 1'b0, frst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  realtime     fhalf = 6.5;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [int];   // behavioural register model for config readback

  mtm_timer_top u0 (.clk(clk), .rst_n(rst_n), .fclk(fclk), .frst_n(frst_n),
                    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                    .bus_rdata(bus_rdata), .irq(irq));

  initial forever #2.5 clk = ~clk;
  initial forever #(fhalf) fclk = ~fclk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 6'(a);
    #1 v = bus_rdata;
  endtask

  task automatic wcfg(input int a, input logic [31:0] d, input logic [31:0] mask);
    wr(a, d);
    model[a] = d & mask;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fwait(input int n);
    repeat (n) @(posedge fclk);
  endtask

  task automatic capture(input int t, output logic [31:0] v);
    logic [31:0] b;
    wr(A_CAP + t, 32'h1);
    rd(A_BUSY, b);
    chk(b[t] == 1'b1, "R4 busy after request", b, 32'(1 << t));
    for (int i = 0; i < 100; i++) begin
      rd(A_BUSY, b);
      if (b[t] == 1'b0) break;
    end
    chk(b[t] == 1'b0, "R4 busy clears", b, 32'h0);
    rd(A_CAP + t, v);
  endtask

  task automatic stop_all();
    wr(A_EN, 32'h0);
    idle(4);
    fwait(4);
    idle(10);
  endtask

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    idle(8);
    rst_n = 1'b1; frst_n = 1'b1;
    idle(4);

    // R11: reset state
    for (int a = 0; a <= A_BUSY; a++) begin
      rd(a, v);
      chk(v == 32'h0, "R11 reset value", v, 32'h0);
    end
    chk(irq == 1'b0, "R11 irq low", 32'(irq), 32'h0);

    // R9: readback masking
    wcfg(A_SEL, 32'hFFFF_FFFE, 32'h3);
    wcfg(A_IE, 32'hFFFF_FFFF, 32'h1FF);
    wcfg(A_EN, 32'hFFFF_FFF8, 32'h7);
    wcfg(A_PRE + 1, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    foreach (model[a]) begin
      rd(a, v);
      chk(v == model[a], "R9 readback", v, model[a]);
    end
    wcfg(A_IE, 32'h0, 32'h1FF);

    // channel set-up (all disabled)
    wcfg(0, 20, '1); wcfg(1, 10, '1); wcfg(2, 100, '1);
    wcfg(A_PRE + 0, 5, '1); wcfg(A_SEL + 0, 1, 32'h3);
    wcfg(3, 50, '1); wcfg(4, 12, '1); wcfg(5, 200, '1);
    wcfg(A_PRE + 1, 3, '1); wcfg(A_SEL + 1, 2, 32'h3);
    wcfg(6, 3, '1); wcfg(7, 32'h7777, '1); wcfg(8, 32'h8888, '1);
    wcfg(A_PRE + 2, 32'hFFFF_FFF0, '1); wcfg(A_SEL + 2, 1, 32'h3);
    foreach (model[a]) begin
      rd(a, v);
      chk(v == model[a], "R9 readback", v, model[a]);
    end

    // R2 / R6 / R10: channel 0 alone, reload from comparator 0, 13 ns fclk
    wr(A_EN, 32'h1);
    fwait(40);
    stop_all();
    capture(0, c1);
    chk(c1 >= 5 && c1 <= 20, "R2 reload window ch0", c1, 32'd5);
    capture(1, v);
    chk(v == 0, "R10 ch1 idle", v, 32'h0);
    capture(2, v);
    chk(v == 0, "R10 ch2 idle", v, 32'h0);
    rd(A_STS, v);
    chk(v == 32'h3, "R6 status ch0 cmp0/1 only", v, 32'h3);
    chk(irq == 1'b0, "R8 irq masked", 32'(irq), 32'h0);

    // R1: stopped counter holds
    fwait(10);
    capture(0, c2);
    chk(c2 == c1, "R1 hold while disabled", c2, c1);

    // R5: capture write with bit 0 clear is ignored
    wr(A_CAP + 0, 32'h2);
    rd(A_BUSY, v);
    chk(v == 32'h0, "R5 no busy on bit0 clear", v, 32'h0);
    rd(A_CAP + 0, v);
    chk(v == c1, "R5 capture unchanged", v, c1);

    // R8 / R7: interrupt and clear
    wr(A_IE, 32'h2);
    idle(3);
    chk(irq == 1'b1, "R8 irq on enabled status", 32'(irq), 32'h1);
    wr(A_CLR, 32'h3);
    idle(3);
    rd(A_STS, v);
    chk(v == 32'h0, "R7 status cleared", v, 32'h0);
    chk(irq == 1'b0, "R8 irq drops", 32'(irq), 32'h0);
    rd(A_CLR, v);
    chk(v == 32'h0, "R7 clear reads zero", v, 32'h0);
    wr(A_IE, 32'h0);

    // R1: restarting advances the count
    wr(A_EN, 32'h1);
    fwait(3);
    capture(0, v);
    chk(v != c1, "R1 count advances when enabled", v, c1);
    stop_all();
    wr(A_CLR, 32'h1FF);

    // R2: channel 1 reloads from comparator 1
    wr(A_EN, 32'h2);
    fwait(40);
    stop_all();
    capture(1, v);
    chk(v >= 3 && v <= 12, "R2 reload window ch1", v, 32'd3);
    rd(A_STS, v);
    chk(v == 32'h10, "R6 status ch1 cmp1 only", v, 32'h10);
    wr(A_CLR, 32'h1FF);

    // R3: full-range wrap at 37 ns fclk
    fhalf = 18.5;
    wr(A_EN, 32'h4);
    fwait(12);
    stop_all();
    capture(2, v);
    chk(v >= 32'hFFFF_FFF0, "R3 high preload loaded", v, 32'hFFFF_FFF0);
    rd(A_STS, c1);
    chk(c1 == 32'h40, "R6 status ch2 cmp0", c1, 32'h40);
    wr(A_CLR, 32'h1FF);
    wcfg(6, 32'hFFFF_FFFF, '1);
    wcfg(A_PRE + 2, 32'h0, '1);
    wr(A_EN, 32'h4);
    fwait(30);
    stop_all();
    capture(2, v);
    chk(v < 32'h40, "R3 wrapped to low count", v, 32'h0);
    rd(A_STS, c1);
    chk(c1 == 32'h40, "R3 match at top of range", c1, 32'h40);

    // R4: capture while running, non-integer clock ratio
    wr(A_EN, 32'h1);
    fwait(5);
    capture(0, v);
    chk(v >= 5 && v <= 20, "R4 live capture in window", v, 32'd5);
    stop_all();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule